// File: doc/BRIEF.md
# Valley-Skipping Turn-On Controller

This block chooses when the main switch of a quasi-resonant flyback stage turns on. After each switch-off it counts the valleys of the drain ringing. It asks for turn-on at the valley whose index equals a load-dependent target between 1 and 7. The target moves slowly, by one step per adaptation tick. The step direction comes from three comparator flags that report how high the regulation signal has been during the tick window. If the regulation signal crosses the top flag, or the force request is raised, the target drops to 1 at once.

The count of valleys starts only after a ringing suppression window. The window begins at switch-off and its length depends on a second zero-crossing flag, sampled at the moment of switch-off. A maximum off-time timer requests turn-on when no matching valley arrives in time. While burst mode is active no request is issued. The only output is a one-cycle set pulse for the external on/off flip-flop.

Top module: `valley_turnon_ctrl`

## Requirements
- R1: The skip target stays within 1..7. A step up at 7 and a step down at 1 leave it unchanged.
- R2: At each tick, which occurs every TICK_CYCLES cycles after reset, the target changes according to the window that just closed. If `reg_above_low` was never set in the window, the target steps up by 1. If `reg_above_low` was set but `reg_above_high` never was, the target holds. If `reg_above_high` was set but `reg_above_top` never was, the target steps down by 1.
- R3: The cycle after `reg_above_top` is sampled high, the target is 1, with no tick needed.
- R4: The cycle after `force_one` is sampled high, the target is 1.
- R5: A valley is a rising edge of `zc_low`, which marks the falling crossing of the zero-crossing threshold. Each valley counted in an off period increments the valley count. `set_pulse` goes high one cycle after the cycle in which the count equals the target while `zc_low` is high.
- R6: The suppression window covers the first RING_SHORT edges after the edge that samples `gate_on` falling when `zc_above_ring` is 1 at that edge, and the first RING_LONG edges otherwise. Valleys inside the window are not counted.
- R7: With no matching valley, `set_pulse` is high exactly OFF_MAX cycles after the edge that samples `gate_on` falling.
- R8: No `set_pulse` is issued in the cycle after a cycle in which `burst_active` is high. Once burst ends in an off period whose off time has expired, `set_pulse` follows on the next cycle.
- R9: The valley count is cleared when `gate_on` rises, so every off period starts counting from 0.
- R10: `set_pulse` lasts one cycle, occurs at most once per off period, and only after a cycle with `gate_on` low.
- R11: After reset `set_pulse` is 0 and the target is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_above_low | input | 1 | Regulation above the step-up limit |
| reg_above_high | input | 1 | Regulation above the step-down limit |
| reg_above_top | input | 1 | Regulation above the heavy-load limit |
| zc_low | input | 1 | Zero-crossing input below its threshold |
| zc_above_ring | input | 1 | Zero-crossing input above the ring-length level |
| gate_on | input | 1 | Present state of the gate drive |
| burst_active | input | 1 | Burst mode in progress |
| force_one | input | 1 | Request to set the target to 1 |
| set_pulse | output | 1 | One-cycle turn-on request |

## Verification
The assertions assume that `gate_on` rises only in response to a `set_pulse`. They also assume that the regulation flags are nested, so a set top flag implies the high flag and a set high flag implies the low flag, and that every input is synchronous to `clk`. The stimulus changes every input on the falling clock edge and drives the flags only in nested combinations. It raises the gate in the cycle after each expected pulse. The ringing glitches it injects fall inside the suppression window under test and outside the shorter one, so a window of the wrong length shows up as a pulse on the wrong cycle.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  typedef enum logic [1:0] {
    BAND_UNDER = 2'd0,
    BAND_HOLD  = 2'd1,
    BAND_DOWN  = 2'd2,
    BAND_TOP   = 2'd3
  } band_e;

  function automatic band_e classify(input logic lo, input logic hi, input logic top);
    if (top)     return BAND_TOP;
    else if (hi) return BAND_DOWN;
    else if (lo) return BAND_HOLD;
    else         return BAND_UNDER;
  endfunction
endpackage

// File: rtl/vsw_skip_target.sv
module vsw_skip_target #(
  parameter int TICK_CYCLES = 2400000,
  parameter int CNT_MAX     = 7,
  parameter int CW          = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          above_low,
  input  logic          above_high,
  input  logic          above_top,
  input  logic          force_one,
  output logic [CW-1:0] target
);
  import vsw_pkg::*;
  localparam int TW = $clog2(TICK_CYCLES + 1);

  logic [TW-1:0] tick_cnt;
  logic          tick;
  logic          seen_lo, seen_hi, seen_top;
  band_e         band;

  assign tick = (tick_cnt == TW'(TICK_CYCLES - 1));
  assign band = classify(seen_lo | above_low, seen_hi | above_high, seen_top | above_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      seen_lo  <= 1'b0;
      seen_hi  <= 1'b0;
      seen_top <= 1'b0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      seen_lo  <= tick ? 1'b0 : (seen_lo | above_low);
      seen_hi  <= tick ? 1'b0 : (seen_hi | above_high);
      seen_top <= tick ? 1'b0 : (seen_top | above_top);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target <= CW'(1);
    end else if (above_top || force_one) begin
      target <= CW'(1);
    end else if (tick) begin
      case (band)
        BAND_UNDER: if (target != CW'(CNT_MAX)) target <= target + 1'b1;
        BAND_DOWN:  if (target != CW'(1))       target <= target - 1'b1;
        BAND_TOP:   target <= CW'(1);
        default:    target <= target;
      endcase
    end
  end
endmodule

// File: rtl/vsw_off_timers.sv
module vsw_off_timers #(
  parameter int RING_SHORT = 210,
  parameter int RING_LONG  = 2100,
  parameter int OFF_MAX    = 2100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_fall,
  input  logic zc_above_ring,
  output logic ring_done,
  output logic off_expired
);
  localparam int RMAX = (RING_LONG > RING_SHORT) ? RING_LONG : RING_SHORT;
  localparam int RW   = $clog2(RMAX + 1);
  localparam int OW   = $clog2(OFF_MAX + 1);

  logic [RW-1:0] ring_cnt;
  logic [OW-1:0] off_cnt;

  assign ring_done   = (ring_cnt == '0);
  assign off_expired = (off_cnt == OW'(OFF_MAX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_cnt <= '0;
      off_cnt  <= '0;
    end else if (gate_fall) begin
      ring_cnt <= zc_above_ring ? RW'(RING_SHORT) : RW'(RING_LONG);
      off_cnt  <= '0;
    end else begin
      if (!ring_done)   ring_cnt <= ring_cnt - 1'b1;
      if (!off_expired) off_cnt  <= off_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vsw_valley_match.sv
module vsw_valley_match #(
  parameter int CNT_MAX = 7,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_on,
  input  logic          gate_fall,
  input  logic          gate_rise,
  input  logic          zc_low,
  input  logic          burst_active,
  input  logic          ring_done,
  input  logic          off_expired,
  input  logic [CW-1:0] target,
  output logic [CW-1:0] zcc,
  output logic          set_pulse
);
  logic zc_q;
  logic armed;
  logic zc_edge;
  logic open_off;
  logic fire;

  assign zc_edge  = zc_low & ~zc_q;
  assign open_off = armed & ~gate_on;
  assign fire     = open_off & ~burst_active &
                    ((ring_done & zc_low & (zcc == target)) | off_expired);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zc_q      <= 1'b0;
      zcc       <= '0;
      armed     <= 1'b0;
      set_pulse <= 1'b0;
    end else begin
      zc_q      <= zc_low;
      set_pulse <= fire;
      if (gate_rise)
        zcc <= '0;
      else if (zc_edge && open_off && ring_done && zcc != CW'(CNT_MAX))
        zcc <= zcc + 1'b1;
      if (gate_fall)
        armed <= 1'b1;
      else if (fire || gate_rise)
        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/valley_turnon_ctrl.sv
module valley_turnon_ctrl #(
  parameter int TICK_CYCLES = 2400000,
  parameter int RING_SHORT  = 210,
  parameter int RING_LONG   = 2100,
  parameter int OFF_MAX     = 2100,
  parameter int CNT_MAX     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_above_low,
  input  logic reg_above_high,
  input  logic reg_above_top,
  input  logic zc_low,
  input  logic zc_above_ring,
  input  logic gate_on,
  input  logic burst_active,
  input  logic force_one,
  output logic set_pulse
);
  localparam int CW = $clog2(CNT_MAX + 1);

  logic          gate_q;
  logic          gate_fall, gate_rise;
  logic [CW-1:0] target;
  logic [CW-1:0] zcc;
  logic          ring_done, off_expired;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_on;
  end
  assign gate_fall = gate_q & ~gate_on;
  assign gate_rise = ~gate_q & gate_on;

  vsw_skip_target #(.TICK_CYCLES(TICK_CYCLES), .CNT_MAX(CNT_MAX), .CW(CW)) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .above_low(reg_above_low), .above_high(reg_above_high), .above_top(reg_above_top),
    .force_one(force_one), .target(target)
  );

  vsw_off_timers #(.RING_SHORT(RING_SHORT), .RING_LONG(RING_LONG), .OFF_MAX(OFF_MAX)) u_tim (
    .clk(clk), .rst_n(rst_n), .gate_fall(gate_fall), .zc_above_ring(zc_above_ring),
    .ring_done(ring_done), .off_expired(off_expired)
  );

  vsw_valley_match #(.CNT_MAX(CNT_MAX), .CW(CW)) u_match (
    .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .gate_fall(gate_fall), .gate_rise(gate_rise),
    .zc_low(zc_low), .burst_active(burst_active), .ring_done(ring_done),
    .off_expired(off_expired), .target(target), .zcc(zcc), .set_pulse(set_pulse)
  );
endmodule

// File: rtl/vsw_checker.sv
module vsw_checker #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gate_on,
  input logic          burst_active,
  input logic          reg_above_top,
  input logic          force_one,
  input logic          set_pulse,
  input logic [CW-1:0] target,
  input logic [CW-1:0] zcc,
  input logic          ring_done
);
  p_target_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (target != '0) && (target <= CW'(7)));

  p_top_to_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_above_top |=> (target == CW'(1)));

  p_force_to_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    force_one |=> (target == CW'(1)));

  p_ring_freezes_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_done |=> $stable(zcc));

  p_burst_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> !$past(burst_active));

  p_count_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |=> (zcc == '0));

  p_single_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> !set_pulse);

  p_only_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> $past(!gate_on));
endmodule

bind valley_turnon_ctrl vsw_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .burst_active(burst_active),
  .reg_above_top(reg_above_top), .force_one(force_one), .set_pulse(set_pulse),
  .target(target), .zcc(zcc), .ring_done(ring_done)
);

// File: tb/sim_valley_turnon_ctrl.sv
`timescale 1ns/1ps
module sim_valley_turnon_ctrl;
  localparam int TICK  = 200;
  localparam int RSH   = 4;
  localparam int RLG   = 12;
  localparam int OFFM  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo = 1'b0, hi = 1'b0, top = 1'b0;
  logic zc_low = 1'b0, zc_ring = 1'b1;
  logic gate_on = 1'b1, burst = 1'b0, force1 = 1'b0;
  logic set_pulse;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  valley_turnon_ctrl #(.TICK_CYCLES(TICK), .RING_SHORT(RSH), .RING_LONG(RLG),
                       .OFF_MAX(OFFM), .CNT_MAX(7)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_above_low(lo), .reg_above_high(hi),
    .reg_above_top(top), .zc_low(zc_low), .zc_above_ring(zc_ring),
    .gate_on(gate_on), .burst_active(burst), .force_one(force1),
    .set_pulse(set_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops the expected pulse cycle whenever a pulse appears
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && set_pulse) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected pulse", cyc, -1);
        else begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(cyc == e, t, cyc, e);
        end
      end
    end
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // one off period: n valleys after the window, optional glitch edge at rel g, expect pulse at valley k
  task automatic period(input int n, input bit ring_hi, input int g, input int k, input string t);
    int e0, w, p;
    @(negedge clk);
    gate_on = 1'b0; zc_ring = ring_hi; zc_low = 1'b0;
    e0 = cyc + 1;
    w  = ring_hi ? RSH : RLG;
    p  = (k <= n) ? e0 + w + 2 + 4 * (k - 1) : e0 + OFFM;
    exp_q.push_back(p); tag_q.push_back(t);
    forever begin
      @(negedge clk);
      if (cyc >= p) break;
      begin
        automatic int rel = cyc + 1 - e0;
        automatic int d = rel - w - 1;
        automatic bit v = (d >= 0) && (d % 4 < 2) && (d / 4 < n);
        if (g > 0 && (rel == g || rel == g + 1)) v = 1'b1;
        zc_low = v;
      end
    end
    gate_on = 1'b1; zc_low = 1'b0; zc_ring = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(set_pulse == 1'b0, "R11 reset pulse low", set_pulse, 0);
    period(3, 1'b1, 0, 1, "R11 R5 target 1 after reset");
    period(3, 1'b1, 2, 1, "R6 short window ignores glitch");
    period(3, 1'b0, 7, 1, "R6 long window ignores glitch");
    period(3, 1'b1, 0, 1, "R9 count restarts each period");
    // step up three ticks (200,400,600), then hold
    wait_until(602); lo = 1'b1;
    period(7, 1'b1, 0, 4, "R2 up steps then hold at 4");
    wait_until(650); lo = 1'b0;
    wait_until(1402); lo = 1'b1;
    period(7, 1'b1, 0, 7, "R1 upper saturation at 7");
    period(3, 1'b1, 0, 9, "R7 max off time");
    // step down two ticks (1800,2000)
    wait_until(1610); hi = 1'b1;
    wait_until(2000); hi = 1'b0;
    period(7, 1'b1, 0, 5, "R2 down steps to 5");
    wait_until(2050); top = 1'b1; hi = 1'b1;
    @(negedge clk); top = 1'b0; hi = 1'b0;
    period(7, 1'b1, 0, 1, "R3 top flag sets 1 without tick");
    wait_until(2100); lo = 1'b0;
    wait_until(2602); lo = 1'b1;
    period(7, 1'b1, 0, 3, "R2 climb to 3 before force");
    wait_until(2625); force1 = 1'b1;
    @(negedge clk); force1 = 1'b0;
    period(7, 1'b1, 0, 1, "R4 force sets 1");
    wait_until(2700); hi = 1'b1;
    wait_until(2802);
    period(7, 1'b1, 0, 1, "R1 lower saturation at 1");
    // burst: no pulse for whole off period, then release
    wait_until(2900);
    burst = 1'b1; gate_on = 1'b0;
    for (int i = 0; i < 130; i++) begin
      @(negedge clk);
      zc_low = (i % 4 >= 6 - 6) && (i > 6) && (i % 4 < 2);
    end
    check(exp_q.size() == 0, "R8 queue idle during burst", exp_q.size(), 0);
    exp_q.push_back(cyc + 1); tag_q.push_back("R8 pulse after burst ends");
    burst = 1'b0; zc_low = 1'b0;
    @(negedge clk);
    gate_on = 1'b1;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R10 all expected pulses seen", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule